// File: doc/BRIEF.md
# Station Power-Save Wake Scheduler

This block decides when a dozing wireless station turns its receiver back on. Software programs the next TIM and next DTIM beacon times in time units (TU), the repeat period of each, and two wait windows. The block then watches a free-running time counter, `now_i`, which counts in eighths of a TU. It wakes the station a fixed 3 TU ahead of each scheduled beacon. After waking, it waits a bounded time for the beacon to arrive.

- **Beacon after a DTIM wake:** the station stays up to collect buffered broadcast traffic. This wait is limited by its own window, and each more-broadcast indication restarts the window.
- **Beacon after an ordinary TIM wake:** the station stays awake until software asks it to sleep.
- **No beacon in time:** a one-cycle timeout pulse is raised, the station sleeps again, and a missed-beacon counter is incremented. When that counter reaches a programmable threshold, a beacon-miss interrupt pulse is raised.

Software loads the schedule with `cfg_load_i`. Each wake advances the next TIM time by its period, and advances the next DTIM time by its period when the DTIM time was also reached. After reset the station is awake and waits for a sleep request.

Top module: `psw_wake_sched`

## Requirements
- R1: After reset, `awake_o` is 1 and `bcn_timeout_o` and `bmiss_irq_o` are 0.
- R2: While asleep, the station wakes (`awake_o`=1 one cycle later) once `now_i` ≥ (next TIM TU − 3) × 8, and not before.
- R3: The DTIM wake time is (next DTIM TU − 3) × 8. A beacon received after a wake at or past that time keeps the station awake in a broadcast wait.
- R4: If no beacon arrives before `now_i` ≥ wake time + beacon window × 8, `bcn_timeout_o` pulses for one cycle and the station sleeps.
- R5: The broadcast wait ends when `now_i` ≥ start + broadcast window × 8. `more_bcast_i` restarts the window from the current time, and `sleep_req_i` is ignored during the wait.
- R6: Each wake advances the next TIM time by TIM period × 8. A wake that reaches the DTIM time also advances the next DTIM time by DTIM period × 8.
- R7: When the TIM period equals the DTIM period at load, the TIM wake time is taken from the next DTIM value instead of the next TIM value.
- R8: The missed-beacon count clears on any received beacon and increments on each beacon timeout. `bmiss_irq_o` pulses, together with the timeout, when the count reaches a nonzero threshold. A threshold of 0 disables the interrupt.
- R9: A beacon after a non-DTIM wake keeps the station awake until `sleep_req_i`, which puts it to sleep.
- R10: A beacon arriving in the same cycle as the beacon deadline counts as received, so no timeout pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_i | input | 32 | Current time in eighths of a TU |
| cfg_load_i | input | 1 | Load schedule fields |
| cfg_next_tim_i | input | 16 | Next TIM beacon time, TU |
| cfg_next_dtim_i | input | 16 | Next DTIM beacon time, TU |
| cfg_tim_per_i | input | 16 | TIM period, TU |
| cfg_dtim_per_i | input | 16 | DTIM period, TU |
| cfg_bcn_win_i | input | 8 | Beacon wait window, TU |
| cfg_bcast_win_i | input | 8 | Broadcast wait window, TU |
| cfg_miss_thr_i | input | 8 | Missed-beacon threshold (0 = off) |
| beacon_rx_i | input | 1 | Beacon received strobe |
| more_bcast_i | input | 1 | More buffered broadcast follows |
| sleep_req_i | input | 1 | Software sleep request |
| awake_o | output | 1 | Station awake |
| bmiss_irq_o | output | 1 | Beacon-miss interrupt pulse |
| bcn_timeout_o | output | 1 | Beacon wait expired pulse |

## Verification
The following are checked on every cycle:
- a timeout pulse always leaves the station asleep;
- an interrupt never occurs without a timeout;
- a wake only follows a reached wake time;
- a beacon clears the miss count;
- a beacon at the deadline suppresses the timeout;
- a sleep request in the broadcast wait keeps the station awake.

Only the bench scenarios can show the following, because each depends on a programmed schedule evolving across several wakes:
- the exact wake instants with the 3 TU slop;
- the period advance;
- the alignment of TIM to DTIM;
- window extension by more-broadcast;
- the miss count reaching its threshold.

// File: rtl/psw_pkg.sv
// Package: shared state type and fixed constants of the wake scheduler.
// Assumes time is counted in eighths of a TU throughout the block.
package psw_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP      = 2'd0,
        ST_WAIT_BCN   = 2'd1,
        ST_WAIT_BCAST = 2'd2,
        ST_HOLD       = 2'd3
    } psw_state_e;
endpackage

// File: rtl/psw_wake_times.sv
// Holds the next TIM and DTIM wake instants in eighth-TU units.
// Converts programmed TU values with the wake slop, aligns TIM to DTIM when
// both periods match, and advances each time on request from the FSM.
// Assumes the TIM period never exceeds the DTIM period.
module psw_wake_times #(
    parameter int TW   = 32,
    parameter int TUW  = 16,
    parameter int FRAC = 3,
    parameter int SLOP = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  now_i,
    input  logic           load_i,
    input  logic [TUW-1:0] next_tim_i,
    input  logic [TUW-1:0] next_dtim_i,
    input  logic [TUW-1:0] tim_per_i,
    input  logic [TUW-1:0] dtim_per_i,
    input  logic           adv_tim_i,
    input  logic           adv_dtim_i,
    output logic           tim_due_o,
    output logic           dtim_due_o
);
    logic [TW-1:0]  tim_wake_q, dtim_wake_q;
    logic [TW-1:0]  tim_step_q, dtim_step_q;
    logic [TUW-1:0] tim_base;

    // Pick TIM base: align to DTIM when the periods are equal.
    always_comb tim_base = (tim_per_i == dtim_per_i) ? next_dtim_i : next_tim_i;

    // Load or advance the two wake instants and their steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_wake_q  <= '0;
            dtim_wake_q <= '0;
            tim_step_q  <= '0;
            dtim_step_q <= '0;
        end else if (load_i) begin
            tim_wake_q  <= (TW'(tim_base)    - TW'(SLOP)) << FRAC;
            dtim_wake_q <= (TW'(next_dtim_i) - TW'(SLOP)) << FRAC;
            tim_step_q  <= TW'(tim_per_i)  << FRAC;
            dtim_step_q <= TW'(dtim_per_i) << FRAC;
        end else begin
            if (adv_tim_i)  tim_wake_q  <= tim_wake_q  + tim_step_q;
            if (adv_dtim_i) dtim_wake_q <= dtim_wake_q + dtim_step_q;
        end
    end

    // Compare the counter against both wake instants.
    always_comb begin
        tim_due_o  = (now_i >= tim_wake_q);
        dtim_due_o = (now_i >= dtim_wake_q);
    end

    // R6: an advance moves the wake time forward by exactly one step.
    assert_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_tim_i && !load_i) |=> (tim_wake_q == $past(tim_wake_q) + $past(tim_step_q)));
endmodule

// File: rtl/psw_miss_ctr.sv
// Counts consecutive beacon timeouts and raises a one-cycle interrupt when the
// count reaches a nonzero threshold. Any received beacon clears the count.
// Assumes at most one increment per cycle; the count saturates.
module psw_miss_ctr #(
    parameter int MW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    input  logic [MW-1:0] thr_i,
    output logic          irq_o
);
    localparam logic [MW-1:0] CNT_MAX = '1;
    logic [MW-1:0] cnt_q;
    logic [MW-1:0] cnt_nx;

    // Next count value for an increment, saturating at the top.
    always_comb cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

    // Update the count and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_o <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            irq_o <= 1'b0;
        end else if (inc_i) begin
            cnt_q <= cnt_nx;
            irq_o <= (thr_i != '0) && (cnt_nx == thr_i);
        end else begin
            irq_o <= 1'b0;
        end
    end

    // R8: a received beacon leaves the count at zero.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/psw_wake_sched.sv
// Station power-save wake scheduler top. Sleeps until a TIM/DTIM wake time,
// waits a bounded window for the beacon, holds for buffered broadcast after
// DTIM beacons, and stays awake after other beacons until software sleeps it.
// Assumes now_i is monotonic in eighth-TU units and does not wrap in use.
module psw_wake_sched
    import psw_pkg::*;
#(
    parameter int TW   = 32,
    parameter int TUW  = 16,
    parameter int TOW  = 8,
    parameter int MW   = 8,
    parameter int FRAC = 3,
    parameter int SLOP = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  now_i,
    input  logic           cfg_load_i,
    input  logic [TUW-1:0] cfg_next_tim_i,
    input  logic [TUW-1:0] cfg_next_dtim_i,
    input  logic [TUW-1:0] cfg_tim_per_i,
    input  logic [TUW-1:0] cfg_dtim_per_i,
    input  logic [TOW-1:0] cfg_bcn_win_i,
    input  logic [TOW-1:0] cfg_bcast_win_i,
    input  logic [MW-1:0]  cfg_miss_thr_i,
    input  logic           beacon_rx_i,
    input  logic           more_bcast_i,
    input  logic           sleep_req_i,
    output logic           awake_o,
    output logic           bmiss_irq_o,
    output logic           bcn_timeout_o
);
    psw_state_e    state_q;
    logic [TW-1:0] deadline_q;
    logic          dtim_wake_q;
    logic          tim_due, dtim_due;
    logic          wake_evt, expire_evt, past_dl;

    // Event decode for the current cycle.
    always_comb begin
        past_dl    = (now_i >= deadline_q);
        wake_evt   = (state_q == ST_SLEEP) && (tim_due || dtim_due);
        expire_evt = (state_q == ST_WAIT_BCN) && !beacon_rx_i && past_dl;
    end

    psw_wake_times #(.TW(TW), .TUW(TUW), .FRAC(FRAC), .SLOP(SLOP)) u_times (
        .clk         (clk),
        .rst_n       (rst_n),
        .now_i       (now_i),
        .load_i      (cfg_load_i),
        .next_tim_i  (cfg_next_tim_i),
        .next_dtim_i (cfg_next_dtim_i),
        .tim_per_i   (cfg_tim_per_i),
        .dtim_per_i  (cfg_dtim_per_i),
        .adv_tim_i   (wake_evt && tim_due),
        .adv_dtim_i  (wake_evt && dtim_due),
        .tim_due_o   (tim_due),
        .dtim_due_o  (dtim_due)
    );

    psw_miss_ctr #(.MW(MW)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (beacon_rx_i),
        .inc_i (expire_evt),
        .thr_i (cfg_miss_thr_i),
        .irq_o (bmiss_irq_o)
    );

    // Wake state machine with a shared deadline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_HOLD;
            deadline_q    <= '0;
            dtim_wake_q   <= 1'b0;
            bcn_timeout_o <= 1'b0;
        end else begin
            bcn_timeout_o <= expire_evt;
            unique case (state_q)
                ST_SLEEP: if (wake_evt) begin
                    state_q     <= ST_WAIT_BCN;
                    dtim_wake_q <= dtim_due;
                    deadline_q  <= now_i + (TW'(cfg_bcn_win_i) << FRAC);
                end
                ST_WAIT_BCN: begin
                    if (beacon_rx_i && dtim_wake_q) begin
                        state_q    <= ST_WAIT_BCAST;
                        deadline_q <= now_i + (TW'(cfg_bcast_win_i) << FRAC);
                    end else if (beacon_rx_i) begin
                        state_q <= ST_HOLD;
                    end else if (past_dl) begin
                        state_q <= ST_SLEEP;
                    end
                end
                ST_WAIT_BCAST: begin
                    if (more_bcast_i)
                        deadline_q <= now_i + (TW'(cfg_bcast_win_i) << FRAC);
                    else if (past_dl)
                        state_q <= ST_HOLD;
                end
                ST_HOLD: if (sleep_req_i) state_q <= ST_SLEEP;
                default: state_q <= ST_HOLD;
            endcase
        end
    end

    // Awake whenever not in the sleep state.
    always_comb awake_o = (state_q != ST_SLEEP);

    // R4: a timeout pulse always leaves the station asleep.
    assert_timeout_sleeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bcn_timeout_o |-> !awake_o);
    // R8: the miss interrupt only accompanies a timeout.
    assert_irq_with_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bmiss_irq_o |-> bcn_timeout_o);
    // R2: the station only wakes after a wake time was reached.
    assert_wake_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(awake_o) |-> $past(tim_due || dtim_due));
    // R5: a sleep request during the broadcast wait keeps the station awake.
    assert_bcast_no_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BCAST && sleep_req_i) |=> awake_o);
    // R10: a beacon in the waiting state never produces a timeout.
    assert_beacon_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BCN && beacon_rx_i) |=> !bcn_timeout_o);
endmodule

// File: tb/sim_psw_wake_sched.sv
module sim_psw_wake_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] now = '0;
    logic        cfg_load = 1'b0;
    logic [15:0] nt = '0, nd = '0, tp = '0, dp = '0;
    logic [7:0]  bw = 8'd10, cw = 8'd10, thr = 8'd2;
    logic        bcn = 1'b0, more = 1'b0, slp = 1'b0;
    logic        awake, irq, tmo;
    int          checks = 0, errors = 0;

    always #2 clk = ~clk;

    psw_wake_sched u0 (
        .clk(clk), .rst_n(rst_n), .now_i(now), .cfg_load_i(cfg_load),
        .cfg_next_tim_i(nt), .cfg_next_dtim_i(nd), .cfg_tim_per_i(tp),
        .cfg_dtim_per_i(dp), .cfg_bcn_win_i(bw), .cfg_bcast_win_i(cw),
        .cfg_miss_thr_i(thr), .beacon_rx_i(bcn), .more_bcast_i(more),
        .sleep_req_i(slp), .awake_o(awake), .bmiss_irq_o(irq),
        .bcn_timeout_o(tmo)
    );

    // Vector: now[21:6] bcn[5] more[4] sleep[3] exp_awake[2] exp_timeout[1] exp_irq[0]
    localparam logic [21:0] VEC [19] = '{
        {16'd100, 6'b000_000},  // R2 before TIM wake
        {16'd136, 6'b000_100},  // R2 TIM wake
        {16'd200, 6'b000_100},
        {16'd216, 6'b000_010},  // R4 timeout
        {16'd250, 6'b000_000},
        {16'd296, 6'b000_100},  // R3 DTIM wake
        {16'd300, 6'b100_100},  // R3 beacon -> broadcast wait
        {16'd370, 6'b010_100},  // R5 extend
        {16'd420, 6'b001_100},  // R5 sleep ignored
        {16'd450, 6'b000_100},  // R5 wait ends -> hold
        {16'd460, 6'b001_000},  // R9 sleep
        {16'd460, 6'b000_100},  // R6 late TIM wake at 456
        {16'd500, 6'b100_100},  // R9 non-DTIM beacon -> hold
        {16'd510, 6'b001_000},
        {16'd616, 6'b000_100},  // R6 DTIM advanced to 616
        {16'd696, 6'b000_010},  // R8 miss 1
        {16'd776, 6'b000_100},  // R6 TIM advanced to 776
        {16'd856, 6'b000_011},  // R8 miss 2 -> irq
        {16'd900, 6'b000_000}
    };

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic apply(input int t, input logic b, input logic m, input logic s);
        now = 32'(t); bcn = b; more = m; slp = s;
        step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_load = 1'b0; bcn = 1'b0; more = 1'b0; slp = 1'b0; now = '0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic load_and_sleep();
        cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
        apply(0, 1'b0, 1'b0, 1'b1);
        slp = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1", "awake", awake, 1'b1);
        chk("R1", "timeout", tmo, 1'b0);
        chk("R1", "irq", irq, 1'b0);

        nt = 16'd20; nd = 16'd40; tp = 16'd20; dp = 16'd40; thr = 8'd2;
        load_and_sleep();
        chk("R9", "asleep after request", awake, 1'b0);

        for (int i = 0; i < 19; i++) begin
            apply(int'(VEC[i][21:6]), VEC[i][5], VEC[i][4], VEC[i][3]);
            chk($sformatf("R2-vec%0d", i), "awake",   awake, VEC[i][2]);
            chk($sformatf("R4-vec%0d", i), "timeout", tmo,   VEC[i][1]);
            chk($sformatf("R8-vec%0d", i), "irq",     irq,   VEC[i][0]);
        end

        // R7: equal periods align TIM wake to DTIM (376, not 136)
        do_reset();
        nt = 16'd20; nd = 16'd50; tp = 16'd40; dp = 16'd40; thr = 8'd0;
        load_and_sleep();
        apply(200, 1'b0, 1'b0, 1'b0);
        chk("R7", "no wake at unaligned TIM", awake, 1'b0);
        apply(375, 1'b0, 1'b0, 1'b0);
        chk("R7", "no wake one tick early", awake, 1'b0);
        apply(376, 1'b0, 1'b0, 1'b0);
        chk("R7", "wake at aligned DTIM", awake, 1'b1);
        // R10: beacon at the deadline (456) wins
        apply(456, 1'b1, 1'b0, 1'b0);
        chk("R10", "no timeout", tmo, 1'b0);
        chk("R10", "awake", awake, 1'b1);
        apply(500, 1'b0, 1'b0, 1'b1);
        chk("R5", "sleep ignored in broadcast wait", awake, 1'b1);
        apply(536, 1'b0, 1'b0, 1'b0);
        chk("R5", "hold after window", awake, 1'b1);
        apply(540, 1'b0, 1'b0, 1'b1);
        chk("R9", "sleep from hold", awake, 1'b0);
        // R8: threshold 0 disables the interrupt; next wake at 696
        apply(696, 1'b0, 1'b0, 1'b0);
        chk("R6", "wake after one period", awake, 1'b1);
        apply(776, 1'b0, 1'b0, 1'b0);
        chk("R8", "timeout with thr 0", tmo, 1'b1);
        chk("R8", "no irq with thr 0", irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule